// File: doc/BRIEF.md
# Multi-Width Aliased Register File

This block holds the numeric register state of a processor core. Its main array is thirty-two 32-bit floating-point registers. The same storage can be read and written as a single 32-bit register, as a 64-bit even/odd pair, or as a 128-bit group of four consecutive registers. There are two read ports and one write port. Each port carries a width code and a register index. Registers f0 and f1 always read as zero. As a result, the lowest 64-bit pair always reads zero, and the lowest 128-bit group returns zero in its low half.

A companion integer array uses the same port style. It has thirty-two 32-bit registers, two read ports and one write port, and register r0 always reads zero. Read data is registered, so it arrives one clock after the index is presented. Writes land at the clock edge. There is no forwarding between the ports: a read issued in the same cycle as a write to an overlapping register returns the value held before that write.

Top module: `mwrf_top`

## Requirements
- R1: With width code 0 (32 bits), a read of index 2..31 returns that register's last written value in bits 31:0 one cycle after the index is presented, and bits 127:32 are zero.
- R2: Registers f0 and f1 always read as zero, whatever was written to them. A 64-bit read of index 0 therefore returns all zeros, and a 128-bit read of index 0 returns zero in bits 63:0.
- R3: With width code 1 (64 bits) and an even index n, bits 31:0 hold register n, bits 63:32 hold register n+1, and bits 127:64 are zero. A 64-bit write stores data bits 31:0 into n and bits 63:32 into n+1.
- R4: With width code 2 (128 bits) and an index n that is a multiple of four, bits 32k+31:32k hold register n+k for k = 0..3. Writes map the same way.
- R5: An index that does not fit its width is an error: an odd index at width code 1, an index not a multiple of four at width code 2, or any index with width code 3. On a read, the error flag of that port is 1 and the data is zero one cycle later. On a write, no register changes and the write error flag is 1 one cycle later. Otherwise both flags are 0.
- R6: A write takes effect at the clock edge. A read presented in the same cycle as a write to an overlapping register returns the old value, and a read presented in the next cycle returns the new value.
- R7: A wide write that covers f0 or f1 still updates the other registers in its group.
- R8: The integer array returns register r0 as zero even after writes to it. Its other registers read back the last written value one cycle after the index is presented, with the same timing as R6.
- R9: While reset is high, and on the cycle after it, every read data output and every error flag is zero.
- R10: The two floating-point read ports are independent, and each may use a different width and index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fw_en | input | 1 | Floating-point write enable |
| fw_wid | input | 2 | Write width code (0: 32, 1: 64, 2: 128, 3: invalid) |
| fw_idx | input | 5 | Write register index |
| fw_data | input | 128 | Write data, lowest register in the low bits |
| fw_err | output | 1 | Registered write alignment error |
| fa_wid | input | 2 | Read port A width code |
| fa_idx | input | 5 | Read port A register index |
| fa_data | output | 128 | Read port A data |
| fa_err | output | 1 | Read port A alignment error |
| fb_wid | input | 2 | Read port B width code |
| fb_idx | input | 5 | Read port B register index |
| fb_data | output | 128 | Read port B data |
| fb_err | output | 1 | Read port B alignment error |
| iw_en | input | 1 | Integer write enable |
| iw_idx | input | 5 | Integer write index |
| iw_data | input | 32 | Integer write data |
| ia_idx | input | 5 | Integer read port A index |
| ia_data | output | 32 | Integer read port A data |
| ib_idx | input | 5 | Integer read port B index |
| ib_data | output | 32 | Integer read port B data |

## Verification
Read data and read error flags are due one rising edge after the index is presented. The effect of a write can be seen one edge later, through a read presented in the cycle after the write, and the write error flag rises on the same edge as the write. The bench drives each step on a falling edge and samples on the next falling edge. It computes each expected value from its register model before it applies that step's write, so a same-cycle read is compared against the old contents. Reset quietness is checked both while reset is held and when reset is reasserted in the middle of the run.

// File: rtl/mwrf_pkg.sv
package mwrf_pkg;

  localparam int QUAD = 4;

  typedef enum logic [1:0] {
    ACC_W32  = 2'd0,
    ACC_W64  = 2'd1,
    ACC_W128 = 2'd2,
    ACC_BAD  = 2'd3
  } acc_wid_e;

  // Legal width/index combination: low two index bits against width code
  function automatic logic idx_ok(input logic [1:0] wid, input logic [1:0] low);
    case (wid)
      2'd0:    return 1'b1;
      2'd1:    return ~low[0];
      2'd2:    return (low == 2'b00);
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mwrf_bank.sv
// Simple dual-read, single-write memory with registered read data
module mwrf_bank #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Read-before-write: the read samples the array before this edge's write
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_a <= '0;
      rdata_b <= '0;
    end else begin
      rdata_a <= mem[raddr_a];
      rdata_b <= mem[raddr_b];
    end
  end

endmodule

// File: rtl/mwrf_rdmux.sv
// Per read port: registers the access shape and assembles the wide result
module mwrf_rdmux
  import mwrf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NZERO = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         wid,
  input  logic [1:0]         lane,
  input  logic               row0,
  input  logic [QUAD*DW-1:0] bank_q,
  output logic [QUAD*DW-1:0] rd_data,
  output logic               rd_err
);

  logic     ok_q;
  acc_wid_e wid_q;
  logic [1:0] lane_q;
  logic     row0_q;
  logic [QUAD-1:0][DW-1:0] lane_m;

  always_ff @(posedge clk) begin
    if (rst) begin
      ok_q   <= 1'b1;
      wid_q  <= ACC_W32;
      lane_q <= '0;
      row0_q <= 1'b0;
    end else begin
      ok_q   <= idx_ok(wid, lane);
      wid_q  <= acc_wid_e'(wid);
      lane_q <= lane;
      row0_q <= row0;
    end
  end

  // Hardwired-zero registers sit in the first row, lowest lanes
  for (genvar j = 0; j < QUAD; j++) begin : g_mask
    assign lane_m[j] = (row0_q && (j < NZERO)) ? '0 : bank_q[j*DW +: DW];
  end

  always_comb begin
    rd_data = '0;
    rd_err  = ~ok_q;
    if (ok_q) begin
      unique case (wid_q)
        ACC_W32:  rd_data[DW-1:0]   = lane_m[lane_q];
        ACC_W64:  rd_data[2*DW-1:0] = lane_q[1] ? {lane_m[3], lane_m[2]}
                                                : {lane_m[1], lane_m[0]};
        ACC_W128: rd_data           = lane_m;
        default:  rd_data           = '0;
      endcase
    end
  end

endmodule

// File: rtl/mwrf_fp_array.sv
// Four 32-bit lanes; lane k holds every register whose index mod 4 is k
module mwrf_fp_array
  import mwrf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NREG  = 32,
  parameter int NZERO = 2,
  localparam int IDX_W = $clog2(NREG),
  localparam int ROWS  = NREG / QUAD,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_wid,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [QUAD*DW-1:0] wr_data,
  output logic               wr_err,
  input  logic [1:0]         ra_wid,
  input  logic [IDX_W-1:0]   ra_idx,
  output logic [QUAD*DW-1:0] ra_data,
  output logic               ra_err,
  input  logic [1:0]         rb_wid,
  input  logic [IDX_W-1:0]   rb_idx,
  output logic [QUAD*DW-1:0] rb_data,
  output logic               rb_err
);

  logic [ROW_W-1:0] wr_row, ra_row, rb_row;
  logic             wr_ok;
  logic [QUAD*DW-1:0] qa_flat, qb_flat;

  assign wr_row = wr_idx[IDX_W-1:2];
  assign ra_row = ra_idx[IDX_W-1:2];
  assign rb_row = rb_idx[IDX_W-1:2];
  assign wr_ok  = idx_ok(wr_wid, wr_idx[1:0]);

  for (genvar j = 0; j < QUAD; j++) begin : g_lane
    logic          we_j;
    logic [DW-1:0] wd_j;

    always_comb begin
      we_j = 1'b0;
      wd_j = '0;
      if (wr_en && wr_ok) begin
        unique case (acc_wid_e'(wr_wid))
          ACC_W32: begin
            we_j = (wr_idx[1:0] == 2'(j));
            wd_j = wr_data[DW-1:0];
          end
          ACC_W64: begin
            we_j = (wr_idx[1] == 1'(j / 2));
            wd_j = wr_data[(j % 2)*DW +: DW];
          end
          ACC_W128: begin
            we_j = 1'b1;
            wd_j = wr_data[j*DW +: DW];
          end
          default: begin
            we_j = 1'b0;
            wd_j = '0;
          end
        endcase
      end
    end

    mwrf_bank #(.DW(DW), .DEPTH(ROWS)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .we      (we_j),
      .waddr   (wr_row),
      .wdata   (wd_j),
      .raddr_a (ra_row),
      .raddr_b (rb_row),
      .rdata_a (qa_flat[j*DW +: DW]),
      .rdata_b (qb_flat[j*DW +: DW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) wr_err <= 1'b0;
    else     wr_err <= wr_en && !wr_ok;
  end

  mwrf_rdmux #(.DW(DW), .NZERO(NZERO)) u_rda (
    .clk     (clk),
    .rst     (rst),
    .wid     (ra_wid),
    .lane    (ra_idx[1:0]),
    .row0    (ra_row == '0),
    .bank_q  (qa_flat),
    .rd_data (ra_data),
    .rd_err  (ra_err)
  );

  mwrf_rdmux #(.DW(DW), .NZERO(NZERO)) u_rdb (
    .clk     (clk),
    .rst     (rst),
    .wid     (rb_wid),
    .lane    (rb_idx[1:0]),
    .row0    (rb_row == '0),
    .bank_q  (qb_flat),
    .rd_data (rb_data),
    .rd_err  (rb_err)
  );

endmodule

// File: rtl/mwrf_int_array.sv
// Integer companion: flat array, register 0 masked to zero on read
module mwrf_int_array #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [DW-1:0]    ra_data,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [DW-1:0]    rb_data
);

  logic [DW-1:0] qa, qb;
  logic          za_q, zb_q;

  mwrf_bank #(.DW(DW), .DEPTH(NREG)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_en),
    .waddr   (wr_idx),
    .wdata   (wr_data),
    .raddr_a (ra_idx),
    .raddr_b (rb_idx),
    .rdata_a (qa),
    .rdata_b (qb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      za_q <= 1'b1;
      zb_q <= 1'b1;
    end else begin
      za_q <= (ra_idx == '0);
      zb_q <= (rb_idx == '0);
    end
  end

  assign ra_data = za_q ? '0 : qa;
  assign rb_data = zb_q ? '0 : qb;

endmodule

// File: rtl/mwrf_top.sv
module mwrf_top
  import mwrf_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NREG  = 32,
  parameter int NZERO = 2,
  localparam int IDX_W = $clog2(NREG),
  localparam int WIDE  = QUAD * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fw_en,
  input  logic [1:0]       fw_wid,
  input  logic [IDX_W-1:0] fw_idx,
  input  logic [WIDE-1:0]  fw_data,
  output logic             fw_err,
  input  logic [1:0]       fa_wid,
  input  logic [IDX_W-1:0] fa_idx,
  output logic [WIDE-1:0]  fa_data,
  output logic             fa_err,
  input  logic [1:0]       fb_wid,
  input  logic [IDX_W-1:0] fb_idx,
  output logic [WIDE-1:0]  fb_data,
  output logic             fb_err,
  input  logic             iw_en,
  input  logic [IDX_W-1:0] iw_idx,
  input  logic [DW-1:0]    iw_data,
  input  logic [IDX_W-1:0] ia_idx,
  output logic [DW-1:0]    ia_data,
  input  logic [IDX_W-1:0] ib_idx,
  output logic [DW-1:0]    ib_data
);

  mwrf_fp_array #(.DW(DW), .NREG(NREG), .NZERO(NZERO)) u_fp (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (fw_en),
    .wr_wid  (fw_wid),
    .wr_idx  (fw_idx),
    .wr_data (fw_data),
    .wr_err  (fw_err),
    .ra_wid  (fa_wid),
    .ra_idx  (fa_idx),
    .ra_data (fa_data),
    .ra_err  (fa_err),
    .rb_wid  (fb_wid),
    .rb_idx  (fb_idx),
    .rb_data (fb_data),
    .rb_err  (fb_err)
  );

  mwrf_int_array #(.DW(DW), .NREG(NREG)) u_int (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (iw_en),
    .wr_idx  (iw_idx),
    .wr_data (iw_data),
    .ra_idx  (ia_idx),
    .ra_data (ia_data),
    .rb_idx  (ib_idx),
    .rb_data (ib_data)
  );

endmodule

// File: rtl/mwrf_chk.sv
module mwrf_chk #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int IDX_W = $clog2(NREG),
  localparam int WIDE  = 4 * DW
) (
  input logic             clk,
  input logic             rst,
  input logic             fw_en,
  input logic [1:0]       fw_wid,
  input logic [IDX_W-1:0] fw_idx,
  input logic             fw_err,
  input logic [1:0]       fa_wid,
  input logic [IDX_W-1:0] fa_idx,
  input logic [WIDE-1:0]  fa_data,
  input logic             fa_err,
  input logic [1:0]       fb_wid,
  input logic [IDX_W-1:0] fb_idx,
  input logic [WIDE-1:0]  fb_data,
  input logic             fb_err,
  input logic [IDX_W-1:0] ia_idx,
  input logic [DW-1:0]    ia_data,
  input logic [DW-1:0]    ib_data
);

  logic fa_bad, fb_bad, fw_bad;
  assign fa_bad = (fa_wid == 2'd3) || (fa_wid == 2'd1 && fa_idx[0]) || (fa_wid == 2'd2 && fa_idx[1:0] != 2'b00);
  assign fb_bad = (fb_wid == 2'd3) || (fb_wid == 2'd1 && fb_idx[0]) || (fb_wid == 2'd2 && fb_idx[1:0] != 2'b00);
  assign fw_bad = (fw_wid == 2'd3) || (fw_wid == 2'd1 && fw_idx[0]) || (fw_wid == 2'd2 && fw_idx[1:0] != 2'b00);

  AST_RDA_MISALIGN_FLAG: assert property (@(posedge clk) disable iff (rst) fa_bad |=> fa_err); // R5
  AST_RDB_MISALIGN_FLAG: assert property (@(posedge clk) disable iff (rst) fb_bad |=> fb_err); // R5
  AST_RDA_ERR_NO_DATA: assert property (@(posedge clk) disable iff (rst) fa_err |-> (fa_data == '0)); // R5
  AST_WR_MISALIGN_FLAG: assert property (@(posedge clk) disable iff (rst) (fw_en && fw_bad) |=> fw_err); // R5
  AST_WR_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (rst) !fw_en |=> !fw_err); // R5
  AST_SINGLE_ZERO_REG: assert property (@(posedge clk) disable iff (rst) (fa_wid == 2'd0 && fa_idx < IDX_W'(2)) |=> (fa_data == '0)); // R2
  AST_PAIR_ZERO_REG: assert property (@(posedge clk) disable iff (rst) (fa_wid == 2'd1 && fa_idx == '0) |=> (fa_data == '0)); // R2
  AST_SINGLE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst) (fa_wid == 2'd0) |=> (fa_data[WIDE-1:DW] == '0)); // R1
  AST_PAIR_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst) (fb_wid == 2'd1) |=> (fb_data[WIDE-1:2*DW] == '0)); // R3
  AST_INT_ZERO_REG: assert property (@(posedge clk) disable iff (rst) (ia_idx == '0) |=> (ia_data == '0)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (fa_data == '0 && fb_data == '0 && !fa_err && !fb_err && !fw_err && ia_data == '0 && ib_data == '0)); // R9

endmodule

bind mwrf_top mwrf_chk #(.DW(DW), .NREG(NREG)) u_chk (.*);

// File: tb/sim_mwrf_top.sv
`timescale 1ns/1ps
module sim_mwrf_top;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         fw_en = 1'b0;
  logic [1:0]   fw_wid = '0;
  logic [4:0]   fw_idx = '0;
  logic [127:0] fw_data = '0;
  logic         fw_err;
  logic [1:0]   fa_wid = '0, fb_wid = '0;
  logic [4:0]   fa_idx = '0, fb_idx = '0;
  logic [127:0] fa_data, fb_data;
  logic         fa_err, fb_err;
  logic         iw_en = 1'b0;
  logic [4:0]   iw_idx = '0, ia_idx = '0, ib_idx = '0;
  logic [31:0]  iw_data = '0;
  logic [31:0]  ia_data, ib_data;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  logic [31:0] fm [32];

  always #10 clk = ~clk;

  mwrf_top u0 (.*);

  typedef struct packed {
    logic       wen;
    logic [1:0] ww;
    logic [4:0] wi;
    logic [1:0] rw;
    logic [4:0] ri;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd2, 5'd0,  2'd2, 5'd0,  4'd6},  // R6 quad write over f0..f3, same-cycle read old
    '{1'b0, 2'd0, 5'd0,  2'd2, 5'd0,  4'd7},  // R7 f2,f3 updated, low half zero
    '{1'b0, 2'd0, 5'd0,  2'd1, 5'd0,  4'd2},  // R2 lowest pair reads zero
    '{1'b1, 2'd1, 5'd6,  2'd1, 5'd6,  4'd6},  // R6 pair write, old value
    '{1'b0, 2'd0, 5'd0,  2'd1, 5'd6,  4'd3},  // R3 new pair value
    '{1'b1, 2'd0, 5'd1,  2'd0, 5'd1,  4'd2},  // R2 write f1, still zero
    '{1'b1, 2'd1, 5'd3,  2'd0, 5'd3,  4'd5},  // R5 odd pair write suppressed
    '{1'b0, 2'd0, 5'd0,  2'd0, 5'd3,  4'd5},  // R5 f3 unchanged
    '{1'b1, 2'd2, 5'd8,  2'd2, 5'd10, 4'd5},  // R5 misaligned quad read
    '{1'b0, 2'd0, 5'd0,  2'd2, 5'd8,  4'd4},  // R4 quad readback
    '{1'b1, 2'd0, 5'd31, 2'd0, 5'd31, 4'd6},  // R6 single, old
    '{1'b0, 2'd0, 5'd0,  2'd0, 5'd31, 4'd1},  // R1 single, new
    '{1'b1, 2'd3, 5'd4,  2'd3, 5'd4,  4'd5},  // R5 invalid width code
    '{1'b0, 2'd0, 5'd0,  2'd2, 5'd4,  4'd5},  // R5 group 4..7 untouched by invalid write
    '{1'b1, 2'd2, 5'd28, 2'd1, 5'd30, 4'd6},  // R6 quad write, pair read old
    '{1'b0, 2'd0, 5'd0,  2'd2, 5'd28, 4'd4},  // R4 quad new
    '{1'b0, 2'd0, 5'd0,  2'd1, 5'd12, 4'd3},  // R3 untouched pair
    '{1'b1, 2'd1, 5'd2,  2'd0, 5'd2,  4'd6},  // R6 pair write f2,f3, single read old
    '{1'b0, 2'd0, 5'd0,  2'd0, 5'd3,  4'd3}   // R3 high half of pair lands in f3
  };

  function automatic logic al(input logic [1:0] w, input logic [4:0] i);
    if (w == 2'd0) return 1'b1;
    if (w == 2'd1) return (i % 2) == 0;
    if (w == 2'd2) return (i % 4) == 0;
    return 1'b0;
  endfunction

  function automatic logic [31:0] rv(input int i);
    return (i < 2) ? 32'h0 : fm[i];
  endfunction

  function automatic logic [127:0] exp_read(input logic [1:0] w, input logic [4:0] i);
    int b;
    b = int'(i);
    if (!al(w, i)) return '0;
    if (w == 2'd0) return {96'h0, rv(b)};
    if (w == 2'd1) return {64'h0, rv(b + 1), rv(b)};
    return {rv(b + 3), rv(b + 2), rv(b + 1), rv(b)};
  endfunction

  function automatic logic [127:0] wpat(input int s);
    logic [127:0] d;
    for (int k = 0; k < 4; k++) d[32*k +: 32] = 32'hA500_0000 + 32'(s * 256 + k * 17 + 1);
    return d;
  endfunction

  task automatic model_write(input logic [1:0] w, input logic [4:0] i, input logic [127:0] d);
    int n;
    if (!al(w, i)) return;
    n = (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
    for (int k = 0; k < n; k++) fm[int'(i) + k] = d[32*k +: 32];
  endtask

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [127:0] ea, eb;
    logic         eae, ewe;
    vec_t v;

    for (int i = 0; i < 32; i++) fm[i] = '0;
    repeat (3) @(negedge clk);
    // R9: outputs quiet while reset is held
    chk("R9 fa_data in reset", fa_data, '0);
    chk("R9 fb_data in reset", fb_data, '0);
    chk("R9 flags in reset", {125'h0, fa_err, fb_err, fw_err}, '0);
    chk("R9 ia_data in reset", {96'h0, ia_data}, '0);
    rst = 1'b0;

    // Fill every register with a distinct value through single writes
    for (int i = 0; i < 32; i++) begin
      fw_en = 1'b1; fw_wid = 2'd0; fw_idx = 5'(i);
      fw_data = {96'h0, 32'h5000_0000 + 32'(i * 32'h0101)};
      model_write(2'd0, 5'(i), fw_data);
      @(negedge clk);
    end
    fw_en = 1'b0;
    @(negedge clk);

    for (int s = 0; s < NV; s++) begin
      v = VEC[s];
      fw_en = v.wen; fw_wid = v.ww; fw_idx = v.wi; fw_data = wpat(s);
      fa_wid = v.rw; fa_idx = v.ri;
      fb_wid = 2'd0; fb_idx = 5'((s + 2) % 32);
      ea  = exp_read(v.rw, v.ri);
      eae = !al(v.rw, v.ri);
      eb  = exp_read(2'd0, 5'((s + 2) % 32));
      ewe = v.wen && !al(v.ww, v.wi);
      @(negedge clk);
      chk($sformatf("R%0d step %0d fa_data", v.req, s), fa_data, ea);
      chk($sformatf("R%0d step %0d fa_err", v.req, s), {127'h0, fa_err}, {127'h0, eae});
      chk($sformatf("R10 step %0d fb_data", s), fb_data, eb);
      chk($sformatf("R5 step %0d fw_err", s), {127'h0, fw_err}, {127'h0, ewe});
      if (v.wen) model_write(v.ww, v.wi, wpat(s));
    end
    fw_en = 1'b0;

    // R8: integer array timing and zero register
    iw_en = 1'b1; iw_idx = 5'd5; iw_data = 32'h1111_1111; ia_idx = 5'd9; ib_idx = 5'd0;
    @(negedge clk);
    iw_data = 32'h2222_2222; ia_idx = 5'd5; ib_idx = 5'd5;
    @(negedge clk);
    chk("R8 int same-cycle old A", {96'h0, ia_data}, {96'h0, 32'h1111_1111});
    chk("R8 int same-cycle old B", {96'h0, ib_data}, {96'h0, 32'h1111_1111});
    iw_idx = 5'd0; iw_data = 32'hDEAD_BEEF; ia_idx = 5'd5; ib_idx = 5'd0;
    @(negedge clk);
    chk("R8 int new value", {96'h0, ia_data}, {96'h0, 32'h2222_2222});
    chk("R8 int r0 during write", {96'h0, ib_data}, '0);
    iw_en = 1'b0; ia_idx = 5'd0; ib_idx = 5'd5;
    @(negedge clk);
    chk("R8 int r0 after write", {96'h0, ia_data}, '0);
    chk("R8 int port B", {96'h0, ib_data}, {96'h0, 32'h2222_2222});

    // R9: reset reasserted mid-run with an errored write and a live read
    rst = 1'b1; fa_wid = 2'd0; fa_idx = 5'd31; fb_wid = 2'd3;
    fw_en = 1'b1; fw_wid = 2'd3; ia_idx = 5'd5;
    @(negedge clk);
    chk("R9 fa_data under reset", fa_data, '0);
    chk("R9 flags under reset", {125'h0, fa_err, fb_err, fw_err}, '0);
    chk("R9 ia_data under reset", {96'h0, ia_data}, '0);
    rst = 1'b0; fw_en = 1'b0; fb_wid = 2'd0;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule